// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block decides whether unsigned word A is greater than, less than or equal to unsigned word B. It is built from 4-bit comparator slices. Each slice looks at its two nibbles from the most significant bit down. The first bit position where the nibbles differ sets the result. When all four bit pairs match, the result comes from three cascade inputs (greater, equal, less) that are fed from a less significant slice. The top module chains enough slices in series to cover the word width. The operands are zero-padded at the top up to a multiple of four bits. The three cascade inputs at the top feed the least significant slice.

For a plain comparison, tie the cascade inputs to equal high, greater low and less low. In a tree arrangement, the cascade inputs carry results from other comparators. The non-one-hot cascade codes then give defined outputs, and an outer stage can decode those outputs. An optional register stage, selected by a parameter, holds the three results for one clock. The register clears asynchronously to all-low.

Top module: `magcmp_top`

## Requirements
- R1: When the padded operands differ, exactly one of gtOut and ltOut is high and eqOut is low. gtOut is high exactly when opA > opB as unsigned numbers, with the highest bit carrying the most weight.
- R2: When the operands differ, the cascade inputs have no effect on any output.
- R3: Take a slice whose nibbles are equal and whose casEqIn is high. It outputs gt=0, eq=1, lt=0, whatever casGtIn and casLtIn are.
- R4: Take a slice whose nibbles are equal, with casEqIn low and exactly one of casGtIn and casLtIn high. It copies the cascade inputs: (gt,eq,lt) = (1,0,0) or (0,0,1).
- R5: Take a slice whose nibbles are equal, with casEqIn low and both casGtIn and casLtIn high. All three outputs are low.
- R6: Take a slice whose nibbles are equal and all three cascade inputs low. gt and lt are both high and eq is low.
- R7: The top chains ceil(WIDTH/4) slices. Slice k compares bits 4k+3..4k, and its (gt,eq,lt) output feeds the cascade inputs of slice k+1. The top cascade inputs enter slice 0, and the outputs come from the last slice. Bits above WIDTH compare as zero. Each slice applies R3 to R6 in turn, so with equal operands a non-one-hot code alternates from slice to slice.
- R8: With REG_OUT=1, the outputs show the result for the inputs present at the previous rising clock edge, with no combinational path from the inputs. While rstN is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opA | input | WIDTH | Unsigned operand A |
| opB | input | WIDTH | Unsigned operand B |
| casGtIn | input | 1 | Cascade "greater" into the least significant slice |
| casEqIn | input | 1 | Cascade "equal" into the least significant slice |
| casLtIn | input | 1 | Cascade "less" into the least significant slice |
| gtOut | output | 1 | A greater than B result |
| eqOut | output | 1 | A equal to B result |
| ltOut | output | 1 | A less than B result |

## Verification
The single-slice configuration is swept over all nibble pairs under all eight cascade codes. The differing pairs show that the cascade inputs are ignored, and the equal pairs pin every row of the cascade truth table, including the forced and all-low codes. The two-slice configuration, which has a 6-bit width with padding, is swept over every operand pair and every cascade code. This tells a correct bit weighting and slice order apart from a swapped or mis-padded chain. It also shows the slice-to-slice alternation of non-one-hot codes. Reset contents and the one-cycle latency are checked right after reset.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpRes_t;
endpackage

// File: rtl/magcmp_slice.sv
module magcmp_slice
  import magcmp_pkg::*;
(
  input  logic [SLICE_W-1:0] aNib,
  input  logic [SLICE_W-1:0] bNib,
  input  cmpRes_t            casIn,
  output cmpRes_t            resOut
);
  cmpRes_t fallThru;

  // all bit pairs equal: equal input dominates, else cross-inverted copy
  always_comb begin
    fallThru.eq = casIn.eq;
    fallThru.gt = ~casIn.eq & ~casIn.lt;
    fallThru.lt = ~casIn.eq & ~casIn.gt;
  end

  // scan from the most significant bit; first mismatch decides
  always_comb begin
    logic decided;
    decided = 1'b0;
    resOut  = fallThru;
    for (int b = SLICE_W - 1; b >= 0; b--) begin
      if (!decided && (aNib[b] != bNib[b])) begin
        decided   = 1'b1;
        resOut.gt = aNib[b];
        resOut.eq = 1'b0;
        resOut.lt = bNib[b];
      end
    end
  end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  cmpRes_t          casIn,
  output cmpRes_t          resOut
);
  localparam int NSLICE = (WIDTH + SLICE_W - 1) / SLICE_W;
  localparam int PADW   = NSLICE * SLICE_W;

  logic [PADW-1:0] padA;
  logic [PADW-1:0] padB;
  cmpRes_t         link [NSLICE+1];

  assign padA    = PADW'(opA);
  assign padB    = PADW'(opB);
  assign link[0] = casIn;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    magcmp_slice slice_i (
      .aNib  (padA[s*SLICE_W +: SLICE_W]),
      .bNib  (padB[s*SLICE_W +: SLICE_W]),
      .casIn (link[s]),
      .resOut(link[s+1])
    );
  end

  assign resOut = link[NSLICE];
endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
  import magcmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmpRes_t resIn,
  output cmpRes_t resOut
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resOut <= '0;
      else       resOut <= resIn;
    end
  end else begin : g_comb
    assign resOut = resIn;
  end
endmodule

// File: rtl/magcmp_top.sv
module magcmp_top
  import magcmp_pkg::*;
#(
  parameter int WIDTH   = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             casGtIn,
  input  logic             casEqIn,
  input  logic             casLtIn,
  output logic             gtOut,
  output logic             eqOut,
  output logic             ltOut
);
  cmpRes_t casVec;
  cmpRes_t chainRes;
  cmpRes_t finalRes;

  assign casVec = '{gt: casGtIn, eq: casEqIn, lt: casLtIn};

  magcmp_chain #(.WIDTH(WIDTH)) chain_i (
    .opA   (opA),
    .opB   (opB),
    .casIn (casVec),
    .resOut(chainRes)
  );

  magcmp_stage #(.REG_OUT(REG_OUT)) stage_i (
    .clk   (clk),
    .rstN  (rstN),
    .resIn (chainRes),
    .resOut(finalRes)
  );

  assign gtOut = finalRes.gt;
  assign eqOut = finalRes.eq;
  assign ltOut = finalRes.lt;
endmodule

// File: rtl/magcmp_chk.sv
module magcmp_chk #(
  parameter int WIDTH   = 10,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             casGtIn,
  input logic             casEqIn,
  input logic             casLtIn,
  input logic             gtOut,
  input logic             eqOut,
  input logic             ltOut
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  if (REG_OUT) begin : g_props
    // R1: differing operands give a single correct direction
    p_differ_dir_r1: assert property (@(posedge clk) disable iff (!rstN)
      (armed && ($past(opA) != $past(opB))) |->
        (!eqOut && (gtOut == ($past(opA) > $past(opB))) && (ltOut == ($past(opA) < $past(opB)))));

    // R2: cascade input changes alone do not disturb a differing result
    p_cas_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
      (armed && ($past(opA) != $past(opB)) && $stable(opA) && $stable(opB) && $past(armed)) |=>
        ($stable(gtOut) && $stable(ltOut) && $stable(eqOut)));

    // R3: equal operands with cascade equal high report equal only
    p_eq_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
      (armed && ($past(opA) == $past(opB)) && $past(casEqIn)) |->
        (eqOut && !gtOut && !ltOut));

    // R3: equal output never appears with a direction output
    p_eq_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
      eqOut |-> (!gtOut && !ltOut));

    // R8: reset holds all outputs low
    p_reset_low_r8: assert property (@(posedge clk)
      !rstN |=> (!gtOut && !eqOut && !ltOut));
  end
endmodule

bind magcmp_top magcmp_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .opA    (opA),
  .opB    (opB),
  .casGtIn(casGtIn),
  .casEqIn(casEqIn),
  .casLtIn(casLtIn),
  .gtOut  (gtOut),
  .eqOut  (eqOut),
  .ltOut  (ltOut)
);

// File: tb/magcmp_top_tb_top.sv
module magcmp_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [5:0] aW = '0, bW = '0;
  logic [3:0] aN = '0, bN = '0;
  logic [2:0] casW = 3'b010, casN = 3'b010;  // {gt,eq,lt}
  logic       gW, eW, lW, gN, eN, lN;
  int errors = 0;
  int checks = 0;

  magcmp_top #(.WIDTH(6), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .opA(aW), .opB(bW),
    .casGtIn(casW[2]), .casEqIn(casW[1]), .casLtIn(casW[0]),
    .gtOut(gW), .eqOut(eW), .ltOut(lW)
  );

  magcmp_top #(.WIDTH(4), .REG_OUT(1'b1)) dutOne_i (
    .clk(clk), .rstN(rstN), .opA(aN), .opB(bN),
    .casGtIn(casN[2]), .casEqIn(casN[1]), .casLtIn(casN[0]),
    .gtOut(gN), .eqOut(eN), .ltOut(lN)
  );

  // reference: per-slice rule from the requirements, slice 0 first
  function automatic logic [2:0] refCmp(int a, int b, logic [2:0] cas, int n);
    logic [2:0] r;
    r = cas;
    for (int s = 0; s < n; s++) begin
      int na = (a >> (4 * s)) & 15;
      int nb = (b >> (4 * s)) & 15;
      if (na > nb)      r = 3'b100;
      else if (na < nb) r = 3'b001;
      else if (r[1])    r = 3'b010;
      else              r = {~r[0], 1'b0, ~r[2]};
    end
    return r;
  endfunction

  function automatic string sliceTag(int a, int b, logic [2:0] cas);
    if (a != b)                            return (cas == 3'b010) ? "R1" : "R2";
    if (cas[1])                            return "R3";
    if (cas == 3'b100 || cas == 3'b001)    return "R4";
    if (cas == 3'b101)                     return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    aN = 4'hA; bN = 4'hA; aW = 6'h2A; bW = 6'h2A;
    repeat (3) @(negedge clk);
    check("R8 reset one", {gN, eN, lN}, 3'b000);
    check("R8 reset wide", {gW, eW, lW}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    aN = 4'd5; bN = 4'd3; casN = 3'b010;
    #2;
    check("R8 no comb path", {gN, eN, lN}, 3'b010);
    @(negedge clk);
    check("R8 one-cycle latency", {gN, eN, lN}, 3'b100);

    // single slice: every nibble pair under every cascade code
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          aN = 4'(a); bN = 4'(b); casN = 3'(c);
          @(negedge clk);
          check(sliceTag(a, b, 3'(c)), {gN, eN, lN}, refCmp(a, b, 3'(c), 1));
        end
      end
    end

    // two padded slices: every 6-bit pair under every cascade code
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          @(negedge clk);
          aW = 6'(a); bW = 6'(b); casW = 3'(c);
          @(negedge clk);
          check("R7 chain", {gW, eW, lW}, refCmp(a, b, 3'(c), 2));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule